// File: doc/BRIEF.md
# Performance Counter Overflow and Increment Unit

This block is a small performance-monitor unit. It holds three event counters and one cycle counter, all 32 bits wide. Each event counter takes a one-cycle pulse input as its event source. An event-select code chooses the source for each counter. Code zero means the counter is advanced only by software, and any other code means it counts its pulse input. The cycle counter advances once per clock while it runs. When a counter wraps past its all-ones value, it sets an overflow flag. The flag stays set until software writes a one to it or the unit is reset. Disabling a counter, stopping all counters, or zeroing the counters leaves the flags as they are.

Software reaches the unit through a single-cycle read or write strobe with a 4-bit address and 32-bit data. Read data and the access-error output are registered and appear one cycle after the strobe. A mode input separates privileged accesses from user accesses. A privileged access is always accepted. A user access is accepted only while the user-enable bit is set, and a user write to the user-enable register itself is always refused. A refused access changes nothing, returns zero, and raises the error output for one cycle.

Register offsets:
- 0: control. Bit 0 is the global run bit, and it reads back. Bit 1 is a write-one strobe that zeroes the event counters. Bit 2 is a write-one strobe that zeroes the cycle counter.
- 1: enable-set.
- 2: enable-clear.
- 3: overflow flags.
- 4: software increment.
- 5: event select. Counter n uses bits [8n+7:8n].
- 6: user enable, in bit 0.
- 8, 9 and 10: event counters 0, 1 and 2, readable and loadable.
- 11: the cycle counter, readable and loadable.

The enable mask and the flags share one layout: bit 31 is the cycle counter and bit n is event counter n. Enable-set reads and writes the mask in this layout, and so does enable-clear.

Top module: `perf_tally_unit`

## Requirements
- R1: In the flag register, bit 31 is the cycle-counter flag, bits 2 to 0 are the flags of event counters 2 to 0, and bits 30 to 3 read as zero. Writing ones to bits 30 to 3 has no effect.
- R2: An increment that takes a counter from 0xFFFFFFFF to 0 sets that counter's flag on the same clock edge. This holds for a software increment, an event pulse or a cycle tick. Loading a counter through its register never sets a flag.
- R3: A set flag stays 1 until a write to offset 3 has a 1 in that flag's bit position. Writing a 0 to that bit leaves the flag unchanged.
- R4: Clearing a counter's enable bit (offset 2) does not clear its flag. Clearing the global run bit does not clear any flag. Zeroing the counters through the control strobes does not clear any flag.
- R5: The software increment register (offset 4) always reads as zero.
- R6: Writing 1 to bit n of offset 4 advances event counter n by exactly one. This happens only when its event code is 0x00 and the counter is running.
- R7: A software increment of a counter whose event code is not 0x00 is ignored.
- R8: A user access while user-enable is 0 is ignored, returns read data 0, and raises accErr for exactly the next cycle. A user write to offset 6 is always refused in the same way. Privileged accesses are always accepted.
- R9: A counter advances only while the global run bit and its own enable bit are both 1. An event counter with a non-zero code counts one per cycle in which its event input is high. An event counter with code 0x00 ignores its event input.
- R10: If a wrap sets a flag in the same cycle that software clears it, the flag ends at 1.
- R11: The control bit-1 strobe zeroes only the event counters. The bit-2 strobe zeroes only the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accWr | input | 1 | Register write strobe |
| accRd | input | 1 | Register read strobe |
| accUser | input | 1 | 1 = user-mode access, 0 = privileged |
| accAddr | input | 4 | Register offset |
| accWdata | input | 32 | Write data |
| eventIn | input | 3 | Event pulses, bit n feeds event counter n |
| accRdata | output | 32 | Read data, valid the cycle after accRd |
| accErr | output | 1 | One-cycle pulse after a refused access |

## Verification
The hardest case to reach is a counter wrap that lands in the same cycle as a software write clearing the same flag. The flag must already be set, so that a wrong priority would show. The bench first wraps counter 1 once to set its flag. It then loads the counter to 0xFFFFFFFF again. Finally, on one edge, it drives the counter's event pulse together with a flag write that clears that bit.

Reaching the cycle counter's wrap takes a load close to all-ones, because counting there from zero would take about 2^32 cycles. The bench loads it while it is disabled and only then enables it.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  parameter int NUM_EVT  = 3;
  parameter int CNT_W    = 32;
  parameter int ADDR_W   = 4;
  parameter int EVSEL_W  = 8;
  parameter int CYC_BIT  = 31;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENSET  = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd3;
  localparam logic [ADDR_W-1:0] A_SWINC  = 4'd4;
  localparam logic [ADDR_W-1:0] A_EVSEL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_USEREN = 4'd6;
  localparam int CNT_BASE = 8;
  localparam logic [ADDR_W-1:0] A_CYC    = ADDR_W'(CNT_BASE + NUM_EVT);

  typedef struct packed {
    logic [NUM_EVT-1:0] evtLoad;
    logic               cycLoad;
    logic               evtZero;
    logic               cycZero;
    logic [NUM_EVT-1:0] evtClr;
    logic               cycClr;
    logic [NUM_EVT-1:0] swInc;
    logic [NUM_EVT-1:0] evtRun;
    logic               cycRun;
    logic [NUM_EVT-1:0] hwSel;
    logic [CNT_W-1:0]   loadVal;
  } ptu_strobe_t;
endpackage

// File: rtl/ptu_ctrl.sv
module ptu_ctrl
  import ptu_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            accWr,
  input  logic                            accRd,
  input  logic                            accUser,
  input  logic [ADDR_W-1:0]               accAddr,
  input  logic [CNT_W-1:0]                accWdata,
  input  logic [NUM_EVT-1:0]              evtFlag,
  input  logic                            cycFlag,
  input  logic [NUM_EVT-1:0][CNT_W-1:0]   evtCnt,
  input  logic [CNT_W-1:0]                cycCnt,
  output ptu_strobe_t                     strb,
  output logic                            userEn,
  output logic [CNT_W-1:0]                accRdata,
  output logic                            accErr
);
  localparam int PAD_W = CNT_W - 1 - NUM_EVT;

  logic                             globalEn;
  logic                             cycEn;
  logic [NUM_EVT-1:0]               enMask;
  logic [NUM_EVT-1:0][EVSEL_W-1:0]  evSel;
  logic                             accessOk;
  logic                             wrOk;
  logic                             rdOk;
  logic                             denied;
  logic [CNT_W-1:0]                 rdNext;

  assign accessOk = !accUser || userEn;
  assign denied   = ((accWr || accRd) && !accessOk) ||
                    (accWr && accUser && accAddr == A_USEREN);
  assign wrOk     = accWr && !denied;
  assign rdOk     = accRd && !denied;

  always_comb begin
    rdNext = '0;
    case (accAddr)
      A_CTRL:   rdNext = CNT_W'(globalEn);
      A_ENSET,
      A_ENCLR:  rdNext = {cycEn, {PAD_W{1'b0}}, enMask};
      A_FLAG:   rdNext = {cycFlag, {PAD_W{1'b0}}, evtFlag};
      A_EVSEL:  rdNext = CNT_W'(evSel);
      A_USEREN: rdNext = CNT_W'(userEn);
      A_CYC:    rdNext = cycCnt;
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (accAddr == ADDR_W'(CNT_BASE + i)) rdNext = evtCnt[i];
      end
    endcase
  end

  always_comb begin
    strb = '0;
    strb.loadVal = accWdata;
    strb.cycRun  = globalEn && cycEn;
    for (int i = 0; i < NUM_EVT; i++) begin
      strb.evtRun[i] = globalEn && enMask[i];
      strb.hwSel[i]  = (evSel[i] != '0);
    end
    if (wrOk) begin
      case (accAddr)
        A_CTRL: begin
          strb.evtZero = accWdata[1];
          strb.cycZero = accWdata[2];
        end
        A_FLAG: begin
          strb.evtClr = accWdata[NUM_EVT-1:0];
          strb.cycClr = accWdata[CYC_BIT];
        end
        A_SWINC: begin
          for (int i = 0; i < NUM_EVT; i++)
            strb.swInc[i] = accWdata[i] && (evSel[i] == '0);
        end
        A_CYC: strb.cycLoad = 1'b1;
        default: begin
          for (int i = 0; i < NUM_EVT; i++)
            if (accAddr == ADDR_W'(CNT_BASE + i)) strb.evtLoad[i] = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      globalEn <= 1'b0;
      cycEn    <= 1'b0;
      enMask   <= '0;
      evSel    <= '0;
      userEn   <= 1'b0;
      accRdata <= '0;
      accErr   <= 1'b0;
    end else begin
      accErr   <= denied;
      accRdata <= rdOk ? rdNext : '0;
      if (wrOk) begin
        case (accAddr)
          A_CTRL:   globalEn <= accWdata[0];
          A_ENSET: begin
            enMask <= enMask | accWdata[NUM_EVT-1:0];
            cycEn  <= cycEn | accWdata[CYC_BIT];
          end
          A_ENCLR: begin
            enMask <= enMask & ~accWdata[NUM_EVT-1:0];
            cycEn  <= cycEn & ~accWdata[CYC_BIT];
          end
          A_EVSEL:  evSel  <= accWdata[NUM_EVT*EVSEL_W-1:0];
          A_USEREN: userEn <= accWdata[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptu_datapath.sv
module ptu_datapath
  import ptu_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  ptu_strobe_t                     strb,
  input  logic [NUM_EVT-1:0]              eventIn,
  output logic [NUM_EVT-1:0][CNT_W-1:0]   evtCnt,
  output logic [CNT_W-1:0]                cycCnt,
  output logic [NUM_EVT-1:0]              evtFlag,
  output logic                            cycFlag
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic incNow;
    logic wrapNow;
    assign incNow  = strb.evtRun[g] && (strb.swInc[g] || (strb.hwSel[g] && eventIn[g]));
    assign wrapNow = incNow && !strb.evtZero && !strb.evtLoad[g] && (evtCnt[g] == '1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 evtCnt[g] <= '0;
      else if (strb.evtZero)      evtCnt[g] <= '0;
      else if (strb.evtLoad[g])   evtCnt[g] <= strb.loadVal;
      else if (incNow)            evtCnt[g] <= evtCnt[g] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 evtFlag[g] <= 1'b0;
      else if (wrapNow)           evtFlag[g] <= 1'b1;
      else if (strb.evtClr[g])    evtFlag[g] <= 1'b0;
    end
  end

  logic cycWrap;
  assign cycWrap = strb.cycRun && !strb.cycZero && !strb.cycLoad && (cycCnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cycCnt <= '0;
    else if (strb.cycZero)  cycCnt <= '0;
    else if (strb.cycLoad)  cycCnt <= strb.loadVal;
    else if (strb.cycRun)   cycCnt <= cycCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cycFlag <= 1'b0;
    else if (cycWrap)       cycFlag <= 1'b1;
    else if (strb.cycClr)   cycFlag <= 1'b0;
  end
endmodule

// File: rtl/perf_tally_unit.sv
module perf_tally_unit
  import ptu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accWr,
  input  logic               accRd,
  input  logic               accUser,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [CNT_W-1:0]   accWdata,
  input  logic [NUM_EVT-1:0] eventIn,
  output logic [CNT_W-1:0]   accRdata,
  output logic               accErr
);
  ptu_strobe_t                    strb;
  logic                           userEn;
  logic [NUM_EVT-1:0][CNT_W-1:0]  evtCnt;
  logic [CNT_W-1:0]               cycCnt;
  logic [NUM_EVT-1:0]             evtFlag;
  logic                           cycFlag;

  ptu_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .accWr(accWr), .accRd(accRd), .accUser(accUser),
    .accAddr(accAddr), .accWdata(accWdata), .evtFlag(evtFlag), .cycFlag(cycFlag),
    .evtCnt(evtCnt), .cycCnt(cycCnt), .strb(strb), .userEn(userEn),
    .accRdata(accRdata), .accErr(accErr)
  );

  ptu_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .eventIn(eventIn),
    .evtCnt(evtCnt), .cycCnt(cycCnt), .evtFlag(evtFlag), .cycFlag(cycFlag)
  );
endmodule

// File: rtl/ptu_checker.sv
module ptu_checker
  import ptu_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           accWr,
  input logic                           accRd,
  input logic                           accUser,
  input logic [ADDR_W-1:0]              accAddr,
  input logic [CNT_W-1:0]               accRdata,
  input logic                           accErr,
  input ptu_strobe_t                    strb,
  input logic                           userEn,
  input logic [NUM_EVT-1:0][CNT_W-1:0]  evtCnt,
  input logic [CNT_W-1:0]               cycCnt,
  input logic [NUM_EVT-1:0]             evtFlag,
  input logic                           cycFlag
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      evtFlag[g] && !strb.evtClr[g] |=> evtFlag[g]) else $error("flag dropped"); // R3

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      evtCnt[g] == '1 |=> evtCnt[g] != '0 || evtFlag[g] ||
                          $past(strb.evtZero) || $past(strb.evtLoad[g])) else $error("wrap lost"); // R2
  end

  AST_CYC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cycFlag && !strb.cycClr |=> cycFlag) else $error("cycle flag dropped"); // R4

  AST_SWINC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accRd && accAddr == A_SWINC |=> accRdata == '0) else $error("swinc read"); // R5

  AST_DENY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accRd || accWr) && accUser && !userEn |=> accErr && accRdata == '0) else $error("deny"); // R8

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(accRd || accWr) |=> !accErr) else $error("spurious err"); // R8

  AST_CYC_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.cycRun && !strb.cycZero && !strb.cycLoad |=> $stable(cycCnt)) else $error("cycle moved"); // R9
endmodule

bind perf_tally_unit ptu_checker chk_i (
  .clk(clk), .rst_n(rst_n), .accWr(accWr), .accRd(accRd), .accUser(accUser),
  .accAddr(accAddr), .accRdata(accRdata), .accErr(accErr), .strb(strb),
  .userEn(userEn), .evtCnt(evtCnt), .cycCnt(cycCnt), .evtFlag(evtFlag), .cycFlag(cycFlag)
);

// File: tb/perf_tally_unit_tb_top.sv
module perf_tally_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] O_CTRL = 4'd0, O_ENSET = 4'd1, O_ENCLR = 4'd2, O_FLAG = 4'd3,
                         O_SWINC = 4'd4, O_EVSEL = 4'd5, O_USEREN = 4'd6,
                         O_CNT0 = 4'd8, O_CNT1 = 4'd9, O_CNT2 = 4'd10, O_CYC = 4'd11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accWr = 1'b0, accRd = 1'b0, accUser = 1'b0;
  logic [3:0]  accAddr = '0;
  logic [31:0] accWdata = '0;
  logic [2:0]  eventIn = '0;
  logic [31:0] accRdata;
  logic        accErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rdv;
  logic        errv;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_tally_unit dut_i (
    .clk(clk), .rst_n(rst_n), .accWr(accWr), .accRd(accRd), .accUser(accUser),
    .accAddr(accAddr), .accWdata(accWdata), .eventIn(eventIn),
    .accRdata(accRdata), .accErr(accErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic usr = 1'b0);
    @(negedge clk);
    accWr = 1'b1; accAddr = a; accWdata = d; accUser = usr;
    @(negedge clk);
    errv = accErr;
    accWr = 1'b0; accUser = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic usr = 1'b0);
    @(negedge clk);
    accRd = 1'b1; accAddr = a; accUser = usr;
    @(negedge clk);
    rdv = accRdata; errv = accErr;
    accRd = 1'b0; accUser = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    eventIn[n] = 1'b1;
    @(negedge clk);
    eventIn[n] = 1'b0;
  endtask

  task automatic t_reset();
    rd(O_CTRL); chk("R9 reset ctrl", rdv, 32'h0);
    chk("R8 reset err", {31'b0, errv}, 32'h0);
    rd(O_FLAG); chk("R1 reset flags", rdv, 32'h0);
    rd(O_CNT0); chk("R11 reset cnt0", rdv, 32'h0);
  endtask

  task automatic t_swinc();
    wr(O_CTRL, 32'h1); wr(O_ENSET, 32'h7);
    wr(O_SWINC, 32'h5);
    rd(O_CNT0); chk("R6 swinc cnt0", rdv, 32'd1);
    rd(O_CNT1); chk("R6 swinc cnt1 untouched", rdv, 32'd0);
    rd(O_CNT2); chk("R6 swinc cnt2", rdv, 32'd1);
    rd(O_SWINC); chk("R5 swinc reads zero", rdv, 32'h0);
  endtask

  task automatic t_evsel();
    wr(O_EVSEL, 32'h0000_1100);
    wr(O_SWINC, 32'h2);
    rd(O_CNT1); chk("R7 swinc ignored on nonzero code", rdv, 32'd0);
    for (int k = 0; k < 3; k++) pulse(1);
    rd(O_CNT1); chk("R9 event pulses counted", rdv, 32'd3);
    pulse(0);
    rd(O_CNT0); chk("R9 code zero ignores event", rdv, 32'd1);
    wr(O_ENCLR, 32'h2); pulse(1);
    rd(O_CNT1); chk("R9 own enable off", rdv, 32'd3);
    wr(O_ENSET, 32'h2); wr(O_CTRL, 32'h0); pulse(1);
    rd(O_CNT1); chk("R9 global off", rdv, 32'd3);
    wr(O_CTRL, 32'h1); pulse(1);
    rd(O_CNT1); chk("R9 both on", rdv, 32'd4);
  endtask

  task automatic t_wrap_sticky();
    wr(O_FLAG, 32'hFFFF_FFFF);
    rd(O_FLAG); chk("R1 reserved write ignored", rdv, 32'h0);
    wr(O_CNT0, 32'hFFFF_FFFF);
    rd(O_FLAG); chk("R2 load does not set flag", rdv, 32'h0);
    wr(O_SWINC, 32'h1);
    rd(O_CNT0); chk("R2 wrap to zero", rdv, 32'h0);
    rd(O_FLAG); chk("R2 wrap sets flag", rdv, 32'h1);
    wr(O_FLAG, 32'h0);
    rd(O_FLAG); chk("R3 write zero keeps flag", rdv, 32'h1);
    wr(O_ENCLR, 32'h1);
    rd(O_FLAG); chk("R4 enable clear keeps flag", rdv, 32'h1);
    wr(O_CTRL, 32'h0);
    rd(O_FLAG); chk("R4 global off keeps flag", rdv, 32'h1);
    wr(O_CTRL, 32'h3);
    rd(O_FLAG); chk("R4 reset strobe keeps flag", rdv, 32'h1);
    rd(O_CNT1); chk("R11 event zero strobe", rdv, 32'h0);
    wr(O_ENSET, 32'h1);
    wr(O_FLAG, 32'h1);
    rd(O_FLAG); chk("R3 write one clears", rdv, 32'h0);
  endtask

  task automatic t_set_wins();
    wr(O_CNT1, 32'hFFFF_FFFF); pulse(1);
    rd(O_FLAG); chk("R2 event wrap flag", rdv, 32'h2);
    wr(O_CNT1, 32'hFFFF_FFFF);
    @(negedge clk);
    accWr = 1'b1; accAddr = O_FLAG; accWdata = 32'h2; eventIn[1] = 1'b1;
    @(negedge clk);
    accWr = 1'b0; eventIn[1] = 1'b0;
    rd(O_FLAG); chk("R10 set wins over clear", rdv, 32'h2);
    rd(O_CNT1); chk("R10 counter wrapped", rdv, 32'h0);
  endtask

  task automatic t_cycle();
    logic [31:0] first;
    wr(O_CNT2, 32'hFFFF_FFFF); wr(O_SWINC, 32'h4);
    wr(O_CYC, 32'hFFFF_FFFE);
    wr(O_ENSET, 32'h8000_0000);
    repeat (4) @(negedge clk);
    rd(O_FLAG); chk("R2 cycle wrap flag", rdv, 32'h8000_0006);
    wr(O_CNT0, 32'hFFFF_FFFF); wr(O_SWINC, 32'h1);
    rd(O_FLAG); chk("R1 full flag layout", rdv, 32'h8000_0007);
    wr(O_ENCLR, 32'h8000_0000);
    rd(O_CYC); first = rdv;
    repeat (3) @(negedge clk);
    rd(O_CYC); chk("R9 cycle halted", rdv, first);
    wr(O_CNT2, 32'd9);
    wr(O_CTRL, 32'h5);
    rd(O_CYC); chk("R11 cycle zero strobe", rdv, 32'h0);
    rd(O_CNT2); chk("R11 cycle strobe spares event", rdv, 32'd9);
    rd(O_FLAG); chk("R4 cycle reset keeps flags", rdv, 32'h8000_0007);
  endtask

  task automatic t_user();
    wr(O_CNT0, 32'h55);
    rd(O_CNT0, 1'b1);
    chk("R8 denied read data", rdv, 32'h0);
    chk("R8 denied read err", {31'b0, errv}, 32'h1);
    rd(O_CNT0);
    chk("R8 priv read data", rdv, 32'h55);
    chk("R8 err one cycle", {31'b0, errv}, 32'h0);
    wr(O_SWINC, 32'h1, 1'b1);
    chk("R8 denied write err", {31'b0, errv}, 32'h1);
    rd(O_CNT0); chk("R8 denied swinc no effect", rdv, 32'h55);
    wr(O_USEREN, 32'h1);
    wr(O_SWINC, 32'h1, 1'b1);
    chk("R8 user allowed err", {31'b0, errv}, 32'h0);
    rd(O_CNT0, 1'b1); chk("R6 user swinc", rdv, 32'h56);
    wr(O_USEREN, 32'h0, 1'b1);
    chk("R8 user write useren err", {31'b0, errv}, 32'h1);
    rd(O_USEREN, 1'b1); chk("R8 useren unchanged", rdv, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_swinc();
    t_evsel();
    t_wrap_sticky();
    t_set_wins();
    t_cycle();
    t_user();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule